// File: doc/BRIEF.md
# I2C Byte Receiver Paced by Register Reads

This block is the receive half of an I2C bus master. It takes over once the address phase has finished. From then on it clocks in bytes from a slave, and software controls the pace through a small register interface. Writing the control word with the direction bit cleared and the busy bit set puts the block in receive mode with SCL held low. Nothing moves on the bus until software reads the data register. That first read is a dummy read: it returns a meaningless value and starts the first byte.

Each byte is eight data bits, most significant first, sampled on the rising edge of SCL. A ninth clock follows, on which the master drives the acknowledge bit. After that ninth clock the block loads the byte into the data register, raises a receive-full status and an interrupt flag, and holds SCL low. Each later read of the data register returns the held byte and releases SCL for the next one. To end a transfer, software sets the acknowledge-select bit before the final read, so the last byte is refused with a NACK. SCL then stays low whatever is read, until software writes the stop command. The block then drives the stop condition and frees the bus.

SCL and SDA are open-drain. Each is an active-high pull-low enable output, and each has an input that returns the wired bus level. The SCL half period is a programmable number of system clocks.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset the bus is released (scl_oe=0, sda_oe=0), bus_busy=0, irq=0, rdf=0 and rd_data=0.
- R2: In idle, a control write with ctl_wdata bit0=0 (receive direction) and bit2=1 (busy) sets bus_busy and holds SCL low (scl_oe=1). No SCL pulse occurs until the data register is read.
- R3: While clocking, each low half and each high half of SCL lasts max(2, half_div) clocks.
- R4: A byte is assembled from 8 SDA samples, most significant bit first, each taken when SCL is high. On the ninth clock sda_oe=1 (ACK) if ack-select (ctl_wdata bit1, latched by the last control write) was 0 when the byte was started, and sda_oe=0 (NACK) if it was 1.
- R5: At the end of the ninth clock the byte appears on rd_data, rdf=1, irq=1, and SCL is held low.
- R6: A data-register read clears rdf. When the held byte was acknowledged, the read also releases SCL and starts the next byte.
- R7: flag_clr clears irq. If the end of a byte coincides with flag_clr, irq is set.
- R8: After a NACKed byte, SCL stays low across data reads until a stop command.
- R9: A control write with bit2=0 and bit3=0 while SCL is held between bytes runs the stop sequence. SDA is pulled low while SCL is low, then SCL is released, then SDA is released after a further half period, with each step one half period long. bus_busy clears after 3 half periods.
- R10: sda_oe rises only while SCL has been held low for at least one clock. It falls with SCL released only during the stop release.
- R11: If scl_in stays low after SCL is released (slave stretch), the high half is counted from the first clock where scl_in reads high, and the sample is taken there.
- R12: A stop command while a byte is being clocked or while idle is ignored. So is a control write with bit0=1 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | SCL half period in clocks (values below 2 act as 2) |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | bit0 direction (0=receive), bit1 ack-select (1=NACK), bit2 busy, bit3 stop-command |
| dat_rd | input | 1 | Data register read strobe |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| rd_data | output | DATA_W | Data register |
| rdf | output | 1 | Receive data full status |
| irq | output | 1 | Interrupt flag |
| bus_busy | output | 1 | Bus owned by this master |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| scl_in | input | 1 | SCL bus level |
| sda_in | input | 1 | SDA bus level |

## Verification
Two cases are hard to reach from the ports: the interrupt set meeting its own clear in the same cycle, and a slave stretching the high half. For the first, the bench holds flag_clr high across a whole byte. It then counts the cycles in which irq is seen high, which must be exactly one. For the second, a bench slave model pulls scl_in low for a random number of cycles after SCL is released, and the high-half length is checked against the stretch plus the programmed half. Stop commands are injected in the middle of a byte. Random half periods, data and transfer lengths come from a fixed seed.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_LAST, ST_LOW, ST_HIGH, ST_STOP0, ST_STOP1, ST_STOP2
  } rx_st_e;

  // control word, bit3 down to bit0
  typedef struct packed {
    logic stop_n;   // bit3: 0 together with busy=0 requests stop
    logic busy;     // bit2
    logic ack_sel;  // bit1: 1 = send NACK
    logic dir_tx;   // bit0: 0 = receive
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);

  function automatic logic is_rx_start(input ctl_word_t c);
    return !c.dir_tx && c.busy;
  endfunction

  function automatic logic is_stop_req(input ctl_word_t c);
    return !c.busy && !c.stop_n;
  endfunction

endpackage

// File: rtl/i2c_rx_halfclk.sv
module i2c_rx_halfclk #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          first,
  output logic          half_end
);
  logic [CW-1:0] cnt_q;

  assign first    = (cnt_q == '0);
  assign half_end = run && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || half_end)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (shift)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
  import i2c_rx_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              dat_rd,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdf,
  output logic              irq,
  output logic              bus_busy,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in
);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(DATA_W);

  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  function automatic logic sda_next(input rx_st_e s, input logic cur,
                                    input logic on_ack, input logic nack);
    case (s)
      ST_LOW:   return on_ack && !nack;
      ST_STOP0: return 1'b1;
      ST_STOP2: return 1'b0;
      default:  return cur;
    endcase
  endfunction

  ctl_word_t          cw;
  rx_st_e             st_q;
  logic [BIT_W-1:0]   bit_q;
  logic               ack_sel_q, nack_cur_q, sda_q, rdf_q, irq_q;
  logic [DATA_W-1:0]  dat_q, shreg;

  // named internal events
  logic timed, run, first, half_end, sample;
  logic start_go, stop_go, byte_go, byte_done, in_last, stop_rel;

  assign cw        = ctl_word_t'(ctl_wdata);
  assign timed     = st_q inside {ST_LOW, ST_HIGH, ST_STOP0, ST_STOP1, ST_STOP2};
  assign run       = timed && !(st_q == ST_HIGH && !scl_in);
  assign sample    = (st_q == ST_HIGH) && first && scl_in && (bit_q != ACK_IDX);
  assign in_last   = (st_q == ST_LAST);
  assign start_go  = ctl_wr && is_rx_start(cw) && (st_q == ST_IDLE);
  assign stop_go   = ctl_wr && is_stop_req(cw) && (st_q == ST_HOLD || in_last);
  assign byte_go   = dat_rd && (st_q == ST_HOLD) && !stop_go;
  assign byte_done = (st_q == ST_HIGH) && half_end && (bit_q == ACK_IDX);
  assign stop_rel  = (st_q == ST_STOP2);

  i2c_rx_halfclk #(.CW(DIV_W)) u_half (
    .clk(clk), .rst_n(rst_n), .run(run), .lim(half_len(half_div)),
    .first(first), .half_end(half_end)
  );

  i2c_rx_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(byte_go), .shift(sample),
    .din(sda_in), .q(shreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      bit_q      <= '0;
      nack_cur_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_go) st_q <= ST_HOLD;
        ST_HOLD: begin
          if (stop_go) st_q <= ST_STOP0;
          else if (byte_go) begin
            st_q       <= ST_LOW;
            bit_q      <= '0;
            nack_cur_q <= ack_sel_q;
          end
        end
        ST_LAST:  if (stop_go) st_q <= ST_STOP0;
        ST_LOW:   if (half_end) st_q <= ST_HIGH;
        ST_HIGH: begin
          if (half_end) begin
            if (bit_q == ACK_IDX) st_q <= nack_cur_q ? ST_LAST : ST_HOLD;
            else begin
              bit_q <= bit_q + BIT_W'(1);
              st_q  <= ST_LOW;
            end
          end
        end
        ST_STOP0: if (half_end) st_q <= ST_STOP1;
        ST_STOP1: if (half_end) st_q <= ST_STOP2;
        ST_STOP2: if (half_end) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sel_q <= 1'b0;
      sda_q     <= 1'b0;
      rdf_q     <= 1'b0;
      irq_q     <= 1'b0;
      dat_q     <= '0;
    end else begin
      if (ctl_wr) ack_sel_q <= cw.ack_sel;
      if (first && run) sda_q <= sda_next(st_q, sda_q, bit_q == ACK_IDX, nack_cur_q);
      if (byte_done) begin
        dat_q <= shreg;
        rdf_q <= 1'b1;
      end else if (dat_rd) begin
        rdf_q <= 1'b0;
      end
      if (byte_done)     irq_q <= 1'b1;
      else if (flag_clr) irq_q <= 1'b0;
    end
  end

  assign rd_data  = dat_q;
  assign rdf      = rdf_q;
  assign irq      = irq_q;
  assign bus_busy = (st_q != ST_IDLE);
  assign scl_oe   = st_q inside {ST_HOLD, ST_LAST, ST_LOW, ST_STOP0};
  assign sda_oe   = sda_q;
endmodule

// File: rtl/i2c_rx_master_chk.sv
module i2c_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic dat_rd,
  input logic flag_clr,
  input logic rdf,
  input logic irq,
  input logic bus_busy,
  input logic scl_oe,
  input logic sda_oe,
  input logic byte_done,
  input logic stop_go,
  input logic in_last,
  input logic stop_rel
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> (!scl_oe && !sda_oe));

  assert_byte_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (scl_oe && rdf && irq));

  assert_rdf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !byte_done) |=> !rdf);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_done) |=> !irq);

  assert_nack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_last && !stop_go) |=> scl_oe);

  assert_stop_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |=> (bus_busy && scl_oe));

  assert_sda_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));

  assert_sda_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe) |-> stop_rel);
endmodule

bind i2c_rx_master i2c_rx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dat_rd(dat_rd), .flag_clr(flag_clr),
  .rdf(rdf), .irq(irq), .bus_busy(bus_busy), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .byte_done(byte_done), .stop_go(stop_go),
  .in_last(in_last), .stop_rel(stop_rel)
);

// File: tb/i2c_rx_master_tb.sv
`timescale 1ns/1ps
module i2c_rx_master_tb;
  localparam int DIV_W = 8;
  localparam int DW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd3;
  logic ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic dat_rd = 1'b0;
  logic flag_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic rdf, irq, bus_busy, scl_oe, sda_oe, scl_in, sda_in;

  always #2 clk = ~clk;

  // slave model and monitor state
  logic [7:0] cur_byte = 8'h00;
  int k = 9;
  int stretch_req = 0, stretch_cnt = 0, cur_s = 0;
  int hi_run = 0, lo_run = 0, irq_hits = 0;
  int hexp = 3;
  bit lo_valid = 0, prev_scl = 0, ack_obs = 0;
  int vecs = 0, miss = 0;

  assign scl_in = !scl_oe && (stretch_cnt == 0);
  assign sda_in = !sda_oe && ((k < 8) ? cur_byte[7-k] : 1'b1);

  i2c_rx_master #(.DIV_W(DIV_W), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .dat_rd(dat_rd), .flag_clr(flag_clr),
    .rd_data(rd_data), .rdf(rdf), .irq(irq), .bus_busy(bus_busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in)
  );

  function automatic int exp_half(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [3:0] w);
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic rd_pulse();
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (irq) irq_hits++;
    if (stretch_cnt > 0) stretch_cnt--;
    if (prev_scl && !scl_oe) begin
      cur_s = stretch_req; stretch_cnt = stretch_req; stretch_req = 0;
      if (lo_valid) chk(lo_run == hexp, "R3 low half", lo_run, hexp);
      hi_run = 0; lo_valid = 0;
    end
    if (!prev_scl && scl_oe) begin
      if (k < 9) begin
        if (cur_s > 0) chk(hi_run == hexp + cur_s, "R11 stretched high", hi_run, hexp + cur_s);
        else           chk(hi_run == hexp, "R3 high half", hi_run, hexp);
        k++;
      end
      lo_valid = (k < 9); lo_run = 0; cur_s = 0;
    end
    if (!scl_oe) begin
      hi_run++;
      if (k == 8) ack_obs = sda_oe;
    end else lo_run++;
    prev_scl = scl_oe;
  end

  // receive one byte started by a data read from the between-bytes hold
  task automatic rx_byte(input logic [7:0] b, input bit nack, input int stretch,
                         input bit mid_stop, input bit hold_clr);
    int n;
    ctl({2'b01, nack, 1'b0});
    cur_byte = b; k = 0; stretch_req = stretch;
    if (hold_clr) begin flag_clr = 1'b1; irq_hits = 0; end
    rd_pulse();
    chk(!rdf, "R6 read clears rdf", rdf, 0);
    if (mid_stop) begin
      repeat (3 * hexp) @(negedge clk);
      ctl({2'b00, nack, 1'b0});
      chk(bus_busy && (k < 9), "R12 stop mid-byte ignored", bus_busy, 1);
    end
    n = 0;
    while (!rdf && n < 4000) begin @(negedge clk); n++; end
    chk(rdf, "R5 rdf after ninth clock", rdf, 1);
    chk(rd_data == b, "R4 received byte", rd_data, b);
    chk(irq, "R5 irq after byte", irq, 1);
    chk(scl_oe, "R5 SCL held low", scl_oe, 1);
    chk(ack_obs == !nack, "R4 ack bit driven", ack_obs, !nack);
    if (hold_clr) begin
      @(negedge clk);
      flag_clr = 1'b0;
      chk(irq_hits == 1, "R7 set wins over clear", irq_hits, 1);
      chk(!irq, "R7 clear after set", irq, 0);
    end else begin
      repeat (2 * hexp + 3) @(negedge clk);
      chk(scl_oe && rdf, "R5 hold until read", scl_oe, 1);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk(!irq, "R7 flag clear", irq, 0);
    end
  endtask

  task automatic stop_seq();
    int nb, n01;
    bit s11;
    nb = 0; n01 = 0; s11 = 0;
    ctl_wr = 1'b1; ctl_wdata = 4'b0000;
    @(negedge clk);
    ctl_wr = 1'b0;
    while (bus_busy && nb < 1000) begin
      nb++;
      if (scl_oe && sda_oe) s11 = 1;
      if (!scl_oe && sda_oe) n01++;
      @(negedge clk);
    end
    chk(nb == 3 * hexp, "R9 stop length", nb, 3 * hexp);
    chk(n01 == hexp + 1, "R9 SDA low with SCL released", n01, hexp + 1);
    chk(s11, "R9 SDA pulled while SCL low", s11, 1);
    chk(!scl_oe && !sda_oe, "R9 bus released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic transfer(input int hd, input int nbytes, input bit use_mid, input bit use_clr);
    bit held;
    half_div = DIV_W'(hd); hexp = exp_half(hd);
    @(negedge clk);
    ctl(4'b0100);
    chk(bus_busy && scl_oe, "R2 enter receive with SCL low", {bus_busy, scl_oe}, 3);
    held = 1;
    repeat (4 * hexp + 4) begin @(negedge clk); if (!scl_oe) held = 0; end
    chk(held, "R2 no clocking before dummy read", held, 1);
    for (int i = 0; i < nbytes; i++) begin
      rx_byte(8'($urandom_range(0, 255)), i == nbytes - 1,
              ($urandom_range(0, 2) == 0) ? $urandom_range(1, 7) : 0,
              use_mid && i == 0, use_clr && i == 0);
    end
    rd_pulse();
    chk(!rdf, "R6 final read clears rdf", rdf, 0);
    held = 1;
    repeat (4 * hexp + 4) begin @(negedge clk); if (!scl_oe) held = 0; end
    rd_pulse();
    chk(held && scl_oe, "R8 SCL held after NACK", held, 1);
    stop_seq();
  endtask

  initial begin
    void'($urandom(32'h1c2d));
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_busy, "R1 not busy", bus_busy, 0);
    chk(!irq && !rdf, "R1 flags clear", {irq, rdf}, 0);
    chk(rd_data == 0, "R1 data zero", rd_data, 0);

    ctl(4'b0000);
    repeat (3) @(negedge clk);
    chk(!bus_busy && !scl_oe, "R12 stop in idle ignored", bus_busy, 0);
    ctl(4'b0101);
    repeat (3) @(negedge clk);
    chk(!bus_busy && !scl_oe, "R12 transmit-direction write ignored", bus_busy, 0);

    transfer(3, 3, 1, 1);
    transfer(1, 2, 0, 0);
    transfer(0, 1, 0, 0);
    for (int t = 0; t < 6; t++)
      transfer($urandom_range(2, 6), $urandom_range(1, 4), t == 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule